// File: doc/BRIEF.md
# Signal Control Source Arbiter for a Direct Digital Synthesizer

This block decides, separately for each of the three synthesizer control parameters, which of four data sources drives it. The parameters are the frequency tuning word, the phase offset and the amplitude. The four sources are the programmable modulus path, the digital ramp generator, the profile registers and the parallel data port. Each source has an enable. The ramp generator and the parallel port each carry a destination select that names the one parameter they feed.

For each parameter, the highest-ranked enabled source that targets it wins. The selected value is registered and appears one clock later, together with a code that names the winning source. Two exceptions apply while the modulus path is active. First, the modulus path takes sole ownership of the frequency word. Second, the ramp generator is consumed by the modulus path, so it drives nothing else. Amplitude passes through only while the output-scaling enable is set; otherwise the amplitude word is forced to full scale.

The ramp and parallel-port words are frequency-width words. When such a word targets a narrower parameter, that parameter takes the word's most significant bits.

Top module: `dds_src_arbiter`

## Requirements
- R1: For the frequency word the ranking is modulus, then ramp, then profile, then parallel port. An enabled ramp with destination 0 wins over the profile and the port when modulus is off. Winner codes are 0 none, 1 modulus, 2 ramp, 3 profile, 4 parallel port.
- R2: While modEn is high, freqOut takes modFreq and freqSrc reads 1, whatever the other sources do.
- R3: While modEn is high, the ramp generator never wins phase or amplitude, whatever rampDest is set to.
- R4: While modEn and profEn are both high, phaseOut takes profPhase and ampOut takes profAmp (amplitude only with oskEn high).
- R5: While the ramp generator feeds one parameter and modulus is off, profEn still supplies the other two parameters from the profile values.
- R6: When profEn and portEn are both high and the port targets frequency, the profile supplies the frequency word.
- R7: With oskEn low, ampOut is all ones and ampSrc reads 0. With oskEn high, ampOut is the winning source's amplitude.
- R8: A parameter that no enabled source targets keeps its previous output value, and its winner code reads 0.
- R9: Outputs change one clock after the inputs that select them. Asynchronous active-low reset clears every value output and every winner code to 0.
- R10: Destination select encoding is 0 frequency, 1 phase, 2 amplitude, 3 no target. A ramp or port word routed to phase or amplitude supplies its top PHASE_W or AMP_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modEn | input | 1 | Programmable modulus mode active |
| rampEn | input | 1 | Ramp generator enable |
| rampDest | input | 2 | Ramp destination select |
| profEn | input | 1 | Profile mode enable |
| portEn | input | 1 | Parallel port enable |
| portDest | input | 2 | Parallel port destination select |
| oskEn | input | 1 | Amplitude scaling enable |
| modFreq | input | FREQ_W | Frequency word from modulus path |
| rampWord | input | FREQ_W | Ramp generator word |
| profFreq | input | FREQ_W | Profile frequency word |
| profPhase | input | PHASE_W | Profile phase offset |
| profAmp | input | AMP_W | Profile amplitude |
| portWord | input | FREQ_W | Parallel port word |
| freqOut | output | FREQ_W | Selected frequency word |
| phaseOut | output | PHASE_W | Selected phase offset |
| ampOut | output | AMP_W | Selected amplitude |
| freqSrc | output | 3 | Frequency winner code |
| phaseSrc | output | 3 | Phase winner code |
| ampSrc | output | 3 | Amplitude winner code |

## Verification
The bench builds the block with its default widths: a 32-bit frequency word, a 16-bit phase and a 12-bit amplitude. Because these widths differ, a ramp or port word routed to phase or amplitude shows which top slice it delivered, so a wrong bit range is visible at the outputs. The vector table combines the enables and destination selects so that the modulus takeover, the profile-over-port case, ramp coexistence with profiles and the hold behaviour each appear. Directed steps then cover the reset state and the one-clock latency.

// File: rtl/dds_arb_pkg.sv
package dds_arb_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_MOD  = 3'd1,
    SRC_RAMP = 3'd2,
    SRC_PROF = 3'd3,
    SRC_PORT = 3'd4
  } srcSel_e;

  typedef enum logic [1:0] {
    DEST_FREQ  = 2'd0,
    DEST_PHASE = 2'd1,
    DEST_AMP   = 2'd2,
    DEST_OFF   = 2'd3
  } dest_e;

  typedef struct packed {
    srcSel_e selFreq;
    srcSel_e selPhase;
    srcSel_e selAmp;
    logic    ampForceFull;
  } arbStrobe_t;

endpackage

// File: rtl/dds_arb_ctrl.sv
module dds_arb_ctrl
  import dds_arb_pkg::*;
(
  input  logic       modEn,
  input  logic       rampEn,
  input  logic [1:0] rampDest,
  input  logic       profEn,
  input  logic       portEn,
  input  logic [1:0] portDest,
  input  logic       oskEn,
  output arbStrobe_t strobe
);

  logic rampLive;
  logic rampF, rampP, rampA;
  logic portF, portP, portA;

  // the modulus path consumes the ramp generator while it runs
  assign rampLive = rampEn && !modEn;
  assign rampF = rampLive && (rampDest == DEST_FREQ);
  assign rampP = rampLive && (rampDest == DEST_PHASE);
  assign rampA = rampLive && (rampDest == DEST_AMP);
  assign portF = portEn && (portDest == DEST_FREQ);
  assign portP = portEn && (portDest == DEST_PHASE);
  assign portA = portEn && (portDest == DEST_AMP);

  always_comb begin
    if (modEn)       strobe.selFreq = SRC_MOD;
    else if (rampF)  strobe.selFreq = SRC_RAMP;
    else if (profEn) strobe.selFreq = SRC_PROF;
    else if (portF)  strobe.selFreq = SRC_PORT;
    else             strobe.selFreq = SRC_NONE;

    if (rampP)       strobe.selPhase = SRC_RAMP;
    else if (profEn) strobe.selPhase = SRC_PROF;
    else if (portP)  strobe.selPhase = SRC_PORT;
    else             strobe.selPhase = SRC_NONE;

    if (!oskEn)      strobe.selAmp = SRC_NONE;
    else if (rampA)  strobe.selAmp = SRC_RAMP;
    else if (profEn) strobe.selAmp = SRC_PROF;
    else if (portA)  strobe.selAmp = SRC_PORT;
    else             strobe.selAmp = SRC_NONE;

    strobe.ampForceFull = !oskEn;
  end

  always_comb begin
    AST_MOD_NO_RAMP_PHASE: assert (!(modEn && strobe.selPhase == SRC_RAMP)); // R3
    AST_MOD_NO_RAMP_AMP:   assert (!(modEn && strobe.selAmp == SRC_RAMP));   // R3
  end

endmodule

// File: rtl/dds_arb_dpath.sv
module dds_arb_dpath
  import dds_arb_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobe,
  input  logic [FREQ_W-1:0]  modFreq,
  input  logic [FREQ_W-1:0]  rampWord,
  input  logic [FREQ_W-1:0]  profFreq,
  input  logic [PHASE_W-1:0] profPhase,
  input  logic [AMP_W-1:0]   profAmp,
  input  logic [FREQ_W-1:0]  portWord,
  output logic [FREQ_W-1:0]  freqOut,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [AMP_W-1:0]   ampOut,
  output logic [2:0]         freqSrc,
  output logic [2:0]         phaseSrc,
  output logic [2:0]         ampSrc
);

  localparam logic [AMP_W-1:0] AMP_FULL = {AMP_W{1'b1}};

  logic [PHASE_W-1:0] rampPhase, portPhase;
  logic [AMP_W-1:0]   rampAmp, portAmp;
  logic [FREQ_W-1:0]  freqNext;
  logic [PHASE_W-1:0] phaseNext;
  logic [AMP_W-1:0]   ampNext;

  // narrower parameters take the most significant slice of a wide word
  assign rampPhase = rampWord[FREQ_W-1 -: PHASE_W];
  assign portPhase = portWord[FREQ_W-1 -: PHASE_W];
  assign rampAmp   = rampWord[FREQ_W-1 -: AMP_W];
  assign portAmp   = portWord[FREQ_W-1 -: AMP_W];

  always_comb begin
    case (strobe.selFreq)
      SRC_MOD:  freqNext = modFreq;
      SRC_RAMP: freqNext = rampWord;
      SRC_PROF: freqNext = profFreq;
      SRC_PORT: freqNext = portWord;
      default:  freqNext = freqOut;
    endcase
    case (strobe.selPhase)
      SRC_RAMP: phaseNext = rampPhase;
      SRC_PROF: phaseNext = profPhase;
      SRC_PORT: phaseNext = portPhase;
      default:  phaseNext = phaseOut;
    endcase
    if (strobe.ampForceFull) ampNext = AMP_FULL;
    else begin
      case (strobe.selAmp)
        SRC_RAMP: ampNext = rampAmp;
        SRC_PROF: ampNext = profAmp;
        SRC_PORT: ampNext = portAmp;
        default:  ampNext = ampOut;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqOut  <= '0;
      phaseOut <= '0;
      ampOut   <= '0;
      freqSrc  <= SRC_NONE;
      phaseSrc <= SRC_NONE;
      ampSrc   <= SRC_NONE;
    end else begin
      freqOut  <= freqNext;
      phaseOut <= phaseNext;
      ampOut   <= ampNext;
      freqSrc  <= strobe.selFreq;
      phaseSrc <= strobe.selPhase;
      ampSrc   <= strobe.selAmp;
    end
  end

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selFreq == SRC_NONE) |=> $stable(freqOut)); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selPhase == SRC_NONE) |=> $stable(phaseOut)); // R8
  AST_AMP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ampForceFull |=> (ampOut == AMP_FULL && ampSrc == 3'd0)); // R7

endmodule

// File: rtl/dds_src_arbiter.sv
module dds_src_arbiter
  import dds_arb_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modEn,
  input  logic               rampEn,
  input  logic [1:0]         rampDest,
  input  logic               profEn,
  input  logic               portEn,
  input  logic [1:0]         portDest,
  input  logic               oskEn,
  input  logic [FREQ_W-1:0]  modFreq,
  input  logic [FREQ_W-1:0]  rampWord,
  input  logic [FREQ_W-1:0]  profFreq,
  input  logic [PHASE_W-1:0] profPhase,
  input  logic [AMP_W-1:0]   profAmp,
  input  logic [FREQ_W-1:0]  portWord,
  output logic [FREQ_W-1:0]  freqOut,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [AMP_W-1:0]   ampOut,
  output logic [2:0]         freqSrc,
  output logic [2:0]         phaseSrc,
  output logic [2:0]         ampSrc
);

  arbStrobe_t strobe;

  dds_arb_ctrl u_ctrl (
    .modEn    (modEn),
    .rampEn   (rampEn),
    .rampDest (rampDest),
    .profEn   (profEn),
    .portEn   (portEn),
    .portDest (portDest),
    .oskEn    (oskEn),
    .strobe   (strobe)
  );

  dds_arb_dpath #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modFreq   (modFreq),
    .rampWord  (rampWord),
    .profFreq  (profFreq),
    .profPhase (profPhase),
    .profAmp   (profAmp),
    .portWord  (portWord),
    .freqOut   (freqOut),
    .phaseOut  (phaseOut),
    .ampOut    (ampOut),
    .freqSrc   (freqSrc),
    .phaseSrc  (phaseSrc),
    .ampSrc    (ampSrc)
  );

  AST_MOD_OWNS_FREQ: assert property (@(posedge clk) disable iff (!rstN)
    modEn |=> (freqSrc == 3'd1 && freqOut == $past(modFreq))); // R2
  AST_RAMP_OVER_PROF: assert property (@(posedge clk) disable iff (!rstN)
    (!modEn && rampEn && rampDest == 2'd0) |=> (freqSrc == 3'd2)); // R1
  AST_PROF_OVER_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (!modEn && !(rampEn && rampDest == 2'd0) && profEn && portEn)
      |=> (freqSrc == 3'd3)); // R6
  AST_MOD_PROF_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && profEn) |=> (phaseSrc == 3'd3 && phaseOut == $past(profPhase))); // R4

endmodule

// File: tb/dds_src_arbiter_bench.sv
module dds_src_arbiter_bench;

  localparam int FW = 32;
  localparam int PW = 16;
  localparam int AW = 12;
  localparam int NVEC = 12;

  localparam logic [FW-1:0] V_MOD   = 32'h1111_0001;
  localparam logic [FW-1:0] V_RAMP  = 32'hA5A5_1234;
  localparam logic [FW-1:0] V_PROFF = 32'h2222_0002;
  localparam logic [PW-1:0] V_PROFP = 16'h3333;
  localparam logic [AW-1:0] V_PROFA = 12'h444;
  localparam logic [FW-1:0] V_PORT  = 32'h5A5A_9876;

  // {mod, ramp, rampDest, prof, port, portDest, osk, expF, expP, expA}
  function automatic logic [17:0] mk(bit m, bit r, logic [1:0] rd, bit pf,
      bit pt, logic [1:0] pd, bit o, logic [2:0] f, logic [2:0] p, logic [2:0] a);
    return {m, r, rd, pf, pt, pd, o, f, p, a};
  endfunction

  localparam logic [17:0] VEC [NVEC] = '{
    mk(0,0,2'd3,0,0,2'd3,0, 3'd0,3'd0,3'd0),
    mk(0,0,2'd3,0,1,2'd0,1, 3'd4,3'd0,3'd0),
    mk(0,0,2'd3,1,1,2'd0,1, 3'd3,3'd3,3'd3),
    mk(0,1,2'd1,1,0,2'd3,1, 3'd3,3'd2,3'd3),
    mk(0,1,2'd2,1,0,2'd3,1, 3'd3,3'd3,3'd2),
    mk(0,1,2'd0,1,1,2'd2,1, 3'd2,3'd3,3'd3),
    mk(1,1,2'd1,1,0,2'd3,1, 3'd1,3'd3,3'd3),
    mk(1,1,2'd2,0,1,2'd1,1, 3'd1,3'd4,3'd0),
    mk(1,1,2'd0,0,1,2'd0,0, 3'd1,3'd0,3'd0),
    mk(0,1,2'd3,0,1,2'd3,1, 3'd0,3'd0,3'd0),
    mk(0,1,2'd0,0,1,2'd1,1, 3'd2,3'd4,3'd0),
    mk(0,0,2'd3,0,1,2'd2,1, 3'd0,3'd0,3'd4)
  };

  logic clk = 0;
  logic rstN = 0;
  logic modEn = 0, rampEn = 0, profEn = 0, portEn = 0, oskEn = 0;
  logic [1:0] rampDest = 2'd3, portDest = 2'd3;
  logic [FW-1:0] freqOut;
  logic [PW-1:0] phaseOut;
  logic [AW-1:0] ampOut;
  logic [2:0] freqSrc, phaseSrc, ampSrc;

  int runCnt = 0;
  int failCnt = 0;
  logic [FW-1:0] expF;
  logic [PW-1:0] expP;
  logic [AW-1:0] expA;
  string tagOf [NVEC];

  always #5 clk = ~clk;

  dds_src_arbiter u_dds_src_arbiter (
    .clk(clk), .rstN(rstN), .modEn(modEn), .rampEn(rampEn), .rampDest(rampDest),
    .profEn(profEn), .portEn(portEn), .portDest(portDest), .oskEn(oskEn),
    .modFreq(V_MOD), .rampWord(V_RAMP), .profFreq(V_PROFF), .profPhase(V_PROFP),
    .profAmp(V_PROFA), .portWord(V_PORT), .freqOut(freqOut), .phaseOut(phaseOut),
    .ampOut(ampOut), .freqSrc(freqSrc), .phaseSrc(phaseSrc), .ampSrc(ampSrc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [8:0] c);
    {modEn, rampEn, rampDest, profEn, portEn, portDest, oskEn} = c;
  endtask

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    tagOf = '{"R8 R9 idle", "R1 port freq", "R6 prof over port", "R5 ramp phase",
              "R5 R10 ramp amp", "R1 R10 ramp freq", "R3 R4 mod prof",
              "R3 R8 R10 mod port", "R2 R7 mod osk off", "R8 R10 dest off",
              "R1 R10 ramp port", "R10 port amp"};
    #12;
    // R9 reset state
    chk("R9 reset freq", freqOut, 0);
    chk("R9 reset phase", phaseOut, 0);
    chk("R9 reset amp", ampOut, 0);
    chk("R9 reset srcs", {freqSrc, phaseSrc, ampSrc}, 0);
    @(negedge clk) rstN = 1;
    expF = 0; expP = 0; expA = 0;

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] f, p, a;
      @(negedge clk) drive(VEC[i][17:9]);
      {f, p, a} = VEC[i][8:0];
      case (f)
        3'd1: expF = V_MOD;
        3'd2: expF = V_RAMP;
        3'd3: expF = V_PROFF;
        3'd4: expF = V_PORT;
        default: ;
      endcase
      case (p)
        3'd2: expP = V_RAMP[31:16];
        3'd3: expP = V_PROFP;
        3'd4: expP = V_PORT[31:16];
        default: ;
      endcase
      if (!VEC[i][9]) expA = '1;
      else case (a)
        3'd2: expA = V_RAMP[31:20];
        3'd3: expA = V_PROFA;
        3'd4: expA = V_PORT[31:20];
        default: ;
      endcase
      @(negedge clk);
      chk({tagOf[i], " freqOut"}, freqOut, expF);
      chk({tagOf[i], " phaseOut"}, phaseOut, expP);
      chk({tagOf[i], " ampOut"}, ampOut, expA);
      chk({tagOf[i], " winners"}, {freqSrc, phaseSrc, ampSrc}, {f, p, a});
    end

    // R9 latency: a change is invisible until the next rising edge
    @(negedge clk) drive({1'b0,1'b0,2'd3,1'b0,1'b1,2'd0,1'b1});
    @(negedge clk) drive({1'b1,1'b0,2'd3,1'b0,1'b0,2'd3,1'b1});
    #3;
    chk("R9 before edge", freqOut, V_PORT);
    @(negedge clk);
    chk("R9 after edge R2", freqOut, V_MOD);
    chk("R2 mod winner", freqSrc, 3'd1);

    // R7 amplitude resumes from profile once oskEn rises
    @(negedge clk) drive({1'b0,1'b0,2'd3,1'b1,1'b0,2'd3,1'b0});
    @(negedge clk);
    chk("R7 osk off amp", ampOut, 12'hFFF);
    chk("R7 osk off src", ampSrc, 3'd0);
    drive({1'b0,1'b0,2'd3,1'b1,1'b0,2'd3,1'b1});
    @(negedge clk);
    chk("R7 osk on amp", ampOut, V_PROFA);

    // R9 reset mid-run clears everything
    rstN = 0;
    #1;
    chk("R9 mid reset freq", freqOut, 0);
    chk("R9 mid reset srcs", {freqSrc, phaseSrc, ampSrc}, 0);
    @(negedge clk) rstN = 1;

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule